// File: doc/BRIEF.md
# Serial Display Command/Data Transmitter

This block sends command and data bytes to a display controller over a write-only serial link. Bytes arrive on a valid/ready interface. Each byte carries a flag that is 1 for data and 0 for command. The block frames each byte and shifts it out, most significant bit first, on a serial clock and a serial data line. It also drives an active-low chip select and a separate data/command line.

A static two-bit mode input picks one of three framings:
- mode 0: a nine-bit frame with the flag in front of the byte.
- mode 1: a sixteen-bit word with seven zero padding bits, then the flag, then the byte.
- mode 2 (mode 3 behaves the same): the eight byte bits alone, with the flag carried on the dedicated data/command line.

A runtime divider sets the serial clock rate. A sequencer drives an active-low panel reset pulse and then holds off new input while the panel settles.

Chip select stays asserted across bytes that follow one another without a gap. It is released once the input has been idle for one frame time.

Top module: `dbi_serial_tx`

## Requirements
- R1: In mode 0 each frame carries 9 bits, as sampled on rising serial clock edges: first the flag, then byte bits 7 down to 0. The flag is 1 for data and 0 for command.
- R2: In mode 1 each frame carries 16 bits: seven 0 bits, then the flag, then byte bits 7 down to 0.
- R3: In mode 2 each frame carries only byte bits 7 down to 0. The dcx output equals the flag at every rising edge of the frame and does not change while chip select stays low within a frame.
- R4: The serial clock idles low. sdo changes only while sclk is low. Within a frame, each high phase and each low phase between bits lasts div+1 system clocks.
- R5: csx_n goes low on the cycle after a byte is accepted. If the next byte is accepted at the frame boundary, csx_n stays low, so a back-to-back burst forms one chip-select period.
- R6: When no byte follows, csx_n rises 2·N·(div+1) cycles after the last falling sclk edge, where N is the frame length in bits. sclk is low whenever csx_n is high.
- R7: in_ready is low while a frame is shifting, including on the cycle after an accept. Bytes are accepted only when idle or at a frame boundary.
- R8: A rst_req seen while idle drives panel_rst_n low for max(rst_len,1) cycles. in_ready is low throughout that time.
- R9: After panel_rst_n returns high, in_ready stays low for max(settle_len,1) further cycles.
- R10: During and after reset: csx_n=1, sclk=0, sdo=0, panel_rst_n=1.
- R11: Mode value 3 frames exactly like mode 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Framing select: 0 nine-bit, 1 sixteen-bit, 2/3 eight-bit with separate line |
| div | input | DIV_W | Serial clock divider; sclk = clk / (2·(div+1)) |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte value |
| in_is_data | input | 1 | 1 = data, 0 = command |
| in_ready | output | 1 | Byte accepted when high with in_valid |
| rst_req | input | 1 | Request a panel reset sequence |
| rst_len | input | RST_W | Panel reset low time in cycles |
| settle_len | input | SETTLE_W | Hold-off after reset in cycles |
| csx_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| dcx | output | 1 | Data/command line, high for data |
| panel_rst_n | output | 1 | Panel reset, active low |

## Verification
The assertions assume that mode and div stay constant while csx_n is low or a reset sequence runs. They also assume that rst_req is raised only when the block is idle with chip select released. The stimulus changes mode and div only after waiting for csx_n high with no expected frame pending. It pulses rst_req for one cycle only after the same idle wait. Bursts hold in_valid continuously, so the frame-boundary handover is exercised, and separate single bytes exercise the chip-select release timer.

// File: rtl/dbi_serial_tx.sv
module dbi_serial_tx #(
  parameter int DIV_W    = 8,
  parameter int RST_W    = 16,
  parameter int SETTLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          mode,
  input  logic [DIV_W-1:0]    div,
  input  logic                in_valid,
  input  logic [7:0]          in_data,
  input  logic                in_is_data,
  output logic                in_ready,
  input  logic                rst_req,
  input  logic [RST_W-1:0]    rst_len,
  input  logic [SETTLE_W-1:0] settle_len,
  output logic                csx_n,
  output logic                sclk,
  output logic                sdo,
  output logic                dcx,
  output logic                panel_rst_n
);
  localparam int CW = (RST_W > SETTLE_W) ? RST_W : SETTLE_W;

  typedef enum logic [2:0] {S_IDLE, S_SHIFT, S_HOLD, S_RLOW, S_SETTLE} st_t;

  st_t              st;
  logic [DIV_W-1:0] half;
  logic [15:0]      sr;
  logic [4:0]       bits_left;
  logic [4:0]       nbits;
  logic [5:0]       hold_half;
  logic [CW-1:0]    rcnt;
  logic             csx_q, sclk_q, dcx_q, prst_q;

  logic [15:0] f_bits;
  logic [4:0]  f_len;
  logic        tick, take;
  logic [5:0]  hold_last;

  assign tick      = (half == div);
  assign in_ready  = (st == S_IDLE && !rst_req) || (st == S_HOLD);
  assign take      = in_valid && in_ready;
  assign hold_last = 6'({1'b0, nbits} << 1) - 6'd1;

  always_comb begin
    case (mode)
      2'd0:    begin f_bits = {in_is_data, in_data, 7'b0};   f_len = 5'd9;  end
      2'd1:    begin f_bits = {7'b0, in_is_data, in_data};   f_len = 5'd16; end
      default: begin f_bits = {in_data, 8'b0};               f_len = 5'd8;  end
    endcase
  end

  assign csx_n       = csx_q;
  assign sclk        = sclk_q;
  assign sdo         = sr[15];
  assign dcx         = dcx_q;
  assign panel_rst_n = prst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      half      <= '0;
      sr        <= '0;
      bits_left <= '0;
      nbits     <= '0;
      hold_half <= '0;
      rcnt      <= '0;
      csx_q     <= 1'b1;
      sclk_q    <= 1'b0;
      dcx_q     <= 1'b0;
      prst_q    <= 1'b1;
    end else begin
      case (st)
        S_IDLE: begin
          if (rst_req) begin
            prst_q <= 1'b0;
            rcnt   <= (rst_len == '0) ? '0 : CW'(rst_len - 1'b1);
            st     <= S_RLOW;
          end else if (take) begin
            sr        <= f_bits;
            bits_left <= f_len;
            nbits     <= f_len;
            csx_q     <= 1'b0;
            dcx_q     <= in_is_data;
            half      <= '0;
            sclk_q    <= 1'b0;
            st        <= S_SHIFT;
          end
        end
        S_SHIFT: begin
          if (tick) begin
            half <= '0;
            if (!sclk_q) begin
              sclk_q <= 1'b1;
            end else begin
              sclk_q    <= 1'b0;
              sr        <= sr << 1;
              bits_left <= bits_left - 5'd1;
              if (bits_left == 5'd1) begin
                st        <= S_HOLD;
                hold_half <= '0;
              end
            end
          end else begin
            half <= half + 1'b1;
          end
        end
        S_HOLD: begin
          if (take) begin
            sr        <= f_bits;
            bits_left <= f_len;
            nbits     <= f_len;
            dcx_q     <= in_is_data;
            half      <= '0;
            st        <= S_SHIFT;
          end else if (tick) begin
            half <= '0;
            if (hold_half == hold_last) begin
              csx_q <= 1'b1;
              st    <= S_IDLE;
            end else begin
              hold_half <= hold_half + 6'd1;
            end
          end else begin
            half <= half + 1'b1;
          end
        end
        S_RLOW: begin
          if (rcnt == '0) begin
            prst_q <= 1'b1;
            rcnt   <= (settle_len == '0) ? '0 : CW'(settle_len - 1'b1);
            st     <= S_SETTLE;
          end else begin
            rcnt <= rcnt - 1'b1;
          end
        end
        S_SETTLE: begin
          if (rcnt == '0) st <= S_IDLE;
          else            rcnt <= rcnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dbi_serial_tx_chk.sv
module dbi_serial_tx_chk #(
  parameter int DIV_W    = 8,
  parameter int RST_W    = 16,
  parameter int SETTLE_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          mode,
  input logic [DIV_W-1:0]    div,
  input logic                in_valid,
  input logic [7:0]          in_data,
  input logic                in_is_data,
  input logic                in_ready,
  input logic                rst_req,
  input logic [RST_W-1:0]    rst_len,
  input logic [SETTLE_W-1:0] settle_len,
  input logic                csx_n,
  input logic                sclk,
  input logic                sdo,
  input logic                dcx,
  input logic                panel_rst_n
);
  a_r6_sclk_low_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    csx_n |-> !sclk);

  a_r7_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  a_r7_busy_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !in_ready);

  a_r4_sdo_still_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdo));

  a_r5_select_on_take: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !csx_n);

  a_r8_busy_in_panel_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !panel_rst_n |-> !in_ready);

  a_r3_dcx_steady_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (!csx_n && $past(!csx_n) && !$past(in_valid && in_ready)) |-> $stable(dcx));
endmodule

bind dbi_serial_tx dbi_serial_tx_chk #(.DIV_W(DIV_W), .RST_W(RST_W), .SETTLE_W(SETTLE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .div(div), .in_valid(in_valid),
  .in_data(in_data), .in_is_data(in_is_data), .in_ready(in_ready),
  .rst_req(rst_req), .rst_len(rst_len), .settle_len(settle_len),
  .csx_n(csx_n), .sclk(sclk), .sdo(sdo), .dcx(dcx), .panel_rst_n(panel_rst_n)
);

// File: tb/dbi_serial_tx_bench.sv
module dbi_serial_tx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [7:0]  div = 8'd0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'd0;
  logic        in_is_data = 1'b0;
  logic        in_ready;
  logic        rst_req = 1'b0;
  logic [15:0] rst_len = 16'd1;
  logic [15:0] settle_len = 16'd1;
  logic        csx_n, sclk, sdo, dcx, panel_rst_n;

  always #5 clk = ~clk;

  dbi_serial_tx u_dbi_serial_tx (
    .clk(clk), .rst_n(rst_n), .mode(mode), .div(div), .in_valid(in_valid),
    .in_data(in_data), .in_is_data(in_is_data), .in_ready(in_ready),
    .rst_req(rst_req), .rst_len(rst_len), .settle_len(settle_len),
    .csx_n(csx_n), .sclk(sclk), .sdo(sdo), .dcx(dcx), .panel_rst_n(panel_rst_n)
  );

  int checks = 0;
  int errors = 0;
  int bursts_exp = 0;
  int cs_rises = 0;
  bit done = 0;

  logic [15:0] q_bits[$];
  int          q_len[$];
  logic        q_flag[$];
  bit          q_sep[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // monitor state
  logic p_sclk = 1'b0, p_sdo = 1'b0, p_csx = 1'b1, p_prst = 1'b1;
  int   ph = 0, nb = 0, since_fall = 0, last_len = 8, low_cnt = 0, sc = 0;
  bit   in_settle = 0;
  logic [15:0] got = '0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (csx_n) chk(!sclk, "R6 sclk low while deselected", sclk, 0);
      if (sclk)  chk(!in_ready, "R7 ready low while shifting", in_ready, 0);
      if (p_sclk && sclk) chk(sdo == p_sdo, "R4 sdo stable while high", sdo, p_sdo);
      if (sclk != p_sclk) begin
        if (!sclk) chk(ph == int'(div) + 1, "R4 high phase length", ph, int'(div) + 1);
        else if (nb > 0) chk(ph == int'(div) + 1, "R4 low phase length", ph, int'(div) + 1);
        ph = 1;
      end else ph++;
      if (!sclk && p_sclk) since_fall = 0; else since_fall++;
      if (sclk && !p_sclk) begin
        chk(!csx_n, "R5 selected at bit", csx_n, 0);
        got = {got[14:0], sdo};
        nb++;
        if (q_len.size() == 0) begin
          chk(0, "R5 unexpected bit", nb, 0);
        end else begin
          if (q_sep[0]) chk(dcx == q_flag[0], "R3 dcx matches flag", dcx, q_flag[0]);
          if (nb == q_len[0]) begin
            logic [15:0] e;
            e = q_bits[0] >> (16 - q_len[0]);
            got = got & ((16'h1 << q_len[0]) - 16'h1);
            if (q_len[0] == 16) got = got;
            chk(got == e, q_len[0] == 9 ? "R1 nine-bit frame" :
                          q_len[0] == 16 ? "R2 sixteen-bit frame" : "R3 R11 eight-bit frame",
                got, e);
            last_len = q_len[0];
            void'(q_bits.pop_front()); void'(q_len.pop_front());
            void'(q_flag.pop_front()); void'(q_sep.pop_front());
            nb = 0;
            got = '0;
          end
        end
      end
      if (csx_n && !p_csx) begin
        cs_rises++;
        chk(since_fall == 2 * last_len * (int'(div) + 1), "R6 release delay",
            since_fall, 2 * last_len * (int'(div) + 1));
      end
      if (!panel_rst_n) begin
        low_cnt++;
        chk(!in_ready, "R8 ready low in panel reset", in_ready, 0);
      end
      if (panel_rst_n && !p_prst) begin
        chk(low_cnt == (rst_len == 0 ? 1 : int'(rst_len)), "R8 reset low width",
            low_cnt, rst_len == 0 ? 1 : int'(rst_len));
        low_cnt = 0; in_settle = 1; sc = 0;
      end
      if (in_settle) begin
        if (!in_ready) sc++;
        else begin
          chk(sc == (settle_len == 0 ? 1 : int'(settle_len)), "R9 settle hold-off",
              sc, settle_len == 0 ? 1 : int'(settle_len));
          in_settle = 0;
        end
      end
      p_sclk = sclk; p_sdo = sdo; p_csx = csx_n; p_prst = panel_rst_n;
    end
  end

  task automatic send(input logic [7:0] d, input logic f, input bit last);
    logic [15:0] e;
    int l;
    in_valid = 1'b1; in_data = d; in_is_data = f;
    while (!in_ready) @(negedge clk);
    case (mode)
      2'd0:    begin e = {f, d, 7'b0}; l = 9;  end
      2'd1:    begin e = {7'b0, f, d}; l = 16; end
      default: begin e = {d, 8'b0};    l = 8;  end
    endcase
    q_bits.push_back(e); q_len.push_back(l); q_flag.push_back(f);
    q_sep.push_back(mode[1]);
    @(negedge clk);
    if (last) in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!(csx_n && q_len.size() == 0 && in_ready && panel_rst_n && !in_settle)) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic burst_check(input string req);
    chk(cs_rises == bursts_exp, req, cs_rises, bursts_exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(csx_n == 1 && sclk == 0 && sdo == 0 && panel_rst_n == 1, "R10 reset outputs",
        {csx_n, sclk, sdo, panel_rst_n}, 4'b1001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(csx_n == 1 && sclk == 0 && panel_rst_n == 1 && in_ready == 1, "R10 after reset",
        {csx_n, sclk, panel_rst_n, in_ready}, 4'b1011);

    // R1: nine-bit, back-to-back burst
    mode = 2'd0; div = 8'd1;
    send(8'h2A, 1'b0, 0); send(8'hA5, 1'b1, 0); send(8'h3C, 1'b1, 1);
    bursts_exp++;
    wait_idle(); burst_check("R5 one select period per burst");

    // R2: sixteen-bit, separate bytes
    mode = 2'd1; div = 8'd0;
    send(8'h81, 1'b1, 1); bursts_exp++; wait_idle();
    send(8'h7E, 1'b0, 1); bursts_exp++; wait_idle();
    burst_check("R6 release between bytes");

    // R3: eight-bit with separate line
    mode = 2'd2; div = 8'd2;
    send(8'hC3, 1'b0, 0); send(8'h5A, 1'b1, 0); send(8'h01, 1'b0, 1);
    bursts_exp++; wait_idle(); burst_check("R3 burst select");

    // R11: mode 3 as eight-bit
    mode = 2'd3; div = 8'd0;
    send(8'hF0, 1'b1, 0); send(8'h0F, 1'b0, 1);
    bursts_exp++; wait_idle(); burst_check("R11 burst select");

    // R8/R9: panel reset sequences
    rst_len = 16'd5; settle_len = 16'd3;
    rst_req = 1'b1; @(negedge clk); rst_req = 1'b0;
    wait_idle();
    rst_len = 16'd0; settle_len = 16'd0;
    rst_req = 1'b1; @(negedge clk); rst_req = 1'b0;
    wait_idle();

    // traffic after reset with a larger divider
    mode = 2'd0; div = 8'd3; rst_len = 16'd1; settle_len = 16'd1;
    send(8'h00, 1'b0, 0); send(8'hFF, 1'b1, 1);
    bursts_exp++; wait_idle(); burst_check("R5 burst after panel reset");

    chk(q_len.size() == 0, "R1 all frames seen", q_len.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", wd, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule